// File: doc/BRIEF.md
# JTAG Debug Register Access Port

This block is a JTAG test access port through which a host reaches a bank of 32-bit debug registers, each selected by a 7-bit index. It holds the 16-state TAP controller, a 5-bit instruction register, a 1-bit bypass register and a 34-bit access data register. The internal side is a plain register bus clocked by TCK. It carries a latched address, one-cycle read and write strobes, write data, read data, and busy and error inputs from the register bank.

Once the access instruction is loaded, every DR scan is one of two phases. An address scan carries a direction bit and the register index. The data scan that follows either returns the register contents or delivers new contents. Busy and error are loaded at Capture-DR and are the first bits out of address and write scans. A scan that captured busy high is discarded and must be repeated. Only a scan that captured busy low moves the phase on.

Top module: `jdp_top`

## Requirements
- R1: `rst_n` low puts the TAP in Test-Logic-Reset at once, and five consecutive TCK rising edges with TMS high reach Test-Logic-Reset from any state. While reset is applied, `tdo`, `reg_rd` and `reg_wr` are 0 and `reg_addr` is 0.
- R2: Capture-IR loads 5'b00001 into the instruction shift path, and Update-IR makes the shifted 5 bits the current instruction. Test-Logic-Reset selects all ones. Code 5'b10000 selects the 34-bit access register. Every other code selects a 1-bit bypass register that captures 0.
- R3: Data and instruction bits enter from `tdi` and leave on `tdo` LSB first. `tdo` updates on the falling edge of TCK and is 0 outside Shift-DR and Shift-IR.
- R4: An address scan takes the register index from bits 33:27 and the direction from bit 26, where 1 means read. Capture in the address or write phase loads busy into bit 0 and error into bit 1, with all other bits 0.
- R5: Update-DR of an address scan that captured busy low latches the index onto `reg_addr` and moves to the data phase. For a read, it also pulses `reg_rd` for the one TCK cycle after Update-DR.
- R6: Capture in the read data phase loads the read data into bits 31:0, busy into bit 32 and error into bit 33. The host may leave Shift-DR after fewer than 34 bits, and the scan still completes normally.
- R7: Update-DR of a write data scan that captured busy low pulses `reg_wr` for the one TCK cycle after Update-DR, with bits 31:0 on `reg_wdata`. Bits 33:32 are ignored.
- R8: A scan whose Capture-DR saw busy high issues no strobe, leaves `reg_addr` unchanged and keeps the current phase.
- R9: Every Update-IR and Test-Logic-Reset return the access register to the address phase.
- R10: `reg_rd` and `reg_wr` are never high together, and each stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| reg_addr | output | 7 | Latched debug register index |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data from the register bank |
| reg_busy | input | 1 | Register bank busy |
| reg_err | input | 1 | Register bank error flag |

## Verification
A phase toggle that is wrong shows at the next scan. An address scan taken as write data puts the index and direction bits into a register, so a later read-back returns a value other than the one the table expects. A read that does not advance the phase shows busy and error at bit 0 instead of bit 32. A wrong TAP state or instruction usually shows within one scan, as a wrong captured pattern on `tdo`. Examples are a bypass path that has not been delayed by one bit, or an IR capture other than 00001. A wrong busy qualification only shows when a later read-back differs.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_t;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } acc_phase_t;

endpackage

// File: rtl/jdp_tap_fsm.sv
module jdp_tap_fsm
  import jdp_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_t st
);

  tap_st_t st_n;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_TLR:    st_n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    st_n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_n = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  st_n = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: st_n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_n = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  st_n = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: st_n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_n = tms ? ST_SEL_DR : ST_RTI;
      default:   st_n = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= ST_TLR;
    else        st <= st_n;
  end

endmodule

// File: rtl/jdp_instr_reg.sv
module jdp_instr_reg
  import jdp_pkg::*;
#(
  parameter int unsigned            IR_W     = 5,
  parameter logic [IR_W-1:0]        ACC_CODE = 5'b10000
) (
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tdi,
  input  tap_st_t st,
  output logic    ir_lsb,
  output logic    sel_acc
);

  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

  logic [IR_W-1:0] ir_sr, ir_sr_n;
  logic [IR_W-1:0] ir_q,  ir_q_n;

  always_comb begin
    ir_sr_n = ir_sr;
    ir_q_n  = ir_q;
    unique case (st)
      ST_TLR:    ir_q_n  = '1;
      ST_CAP_IR: ir_sr_n = CAP_PAT;
      ST_SH_IR:  ir_sr_n = {tdi, ir_sr[IR_W-1:1]};
      ST_UPD_IR: ir_q_n  = ir_sr;
      default:   ;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= CAP_PAT;
      ir_q  <= '1;
    end else begin
      ir_sr <= ir_sr_n;
      ir_q  <= ir_q_n;
    end
  end

  assign ir_lsb  = ir_sr[0];
  assign sel_acc = (ir_q == ACC_CODE);

endmodule

// File: rtl/jdp_acc_dr.sv
module jdp_acc_dr
  import jdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  tap_st_t           st,
  input  logic              sel_acc,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_busy,
  input  logic              reg_err,
  output logic              sr_lsb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata
);

  localparam int unsigned DR_W    = DATA_W + 2;
  localparam int unsigned DIR_BIT = DR_W - 1 - ADDR_W;

  logic [DR_W-1:0]   sr, sr_n;
  acc_phase_t        phase, phase_n;
  logic              dir_q, dir_n;
  logic              bcap, bcap_n;
  logic              rd_n, wr_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] wdata_n;

  always_comb begin
    sr_n    = sr;
    phase_n = phase;
    dir_n   = dir_q;
    bcap_n  = bcap;
    rd_n    = 1'b0;
    wr_n    = 1'b0;
    addr_n  = reg_addr;
    wdata_n = reg_wdata;
    if (st == ST_TLR || st == ST_UPD_IR) phase_n = PH_ADDR;
    if (sel_acc) begin
      unique case (st)
        ST_CAP_DR: begin
          bcap_n = reg_busy;
          if (phase == PH_DATA && dir_q) sr_n = {reg_err, reg_busy, reg_rdata};
          else                           sr_n = DR_W'({reg_err, reg_busy});
        end
        ST_SH_DR: sr_n = {tdi, sr[DR_W-1:1]};
        ST_UPD_DR: begin
          if (!bcap) begin
            if (phase == PH_ADDR) begin
              addr_n  = sr[DR_W-1 -: ADDR_W];
              dir_n   = sr[DIR_BIT];
              rd_n    = sr[DIR_BIT];
              phase_n = PH_DATA;
            end else begin
              wr_n    = ~dir_q;
              if (!dir_q) wdata_n = sr[DATA_W-1:0];
              phase_n = PH_ADDR;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      phase     <= PH_ADDR;
      dir_q     <= 1'b0;
      bcap      <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      sr        <= sr_n;
      phase     <= phase_n;
      dir_q     <= dir_n;
      bcap      <= bcap_n;
      reg_rd    <= rd_n;
      reg_wr    <= wr_n;
      reg_addr  <= addr_n;
      reg_wdata <= wdata_n;
    end
  end

  assign sr_lsb = sr[0];

endmodule

// File: rtl/jdp_top.sv
module jdp_top
  import jdp_pkg::*;
#(
  parameter int unsigned     IR_W     = 5,
  parameter logic [IR_W-1:0] ACC_CODE = 5'b10000,
  parameter int unsigned     ADDR_W   = 7,
  parameter int unsigned     DATA_W   = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_busy,
  input  logic              reg_err
);

  logic [1:0] rst_sync;
  logic       rst_q_n;
  tap_st_t    st;
  logic       ir_lsb, sel_acc, acc_lsb;
  logic       byp, byp_n, tdo_n;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  jdp_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_q_n),
    .tms   (tms),
    .st    (st)
  );

  jdp_instr_reg #(.IR_W(IR_W), .ACC_CODE(ACC_CODE)) u_ir (
    .tck     (tck),
    .rst_n   (rst_q_n),
    .tdi     (tdi),
    .st      (st),
    .ir_lsb  (ir_lsb),
    .sel_acc (sel_acc)
  );

  jdp_acc_dr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .tck       (tck),
    .rst_n     (rst_q_n),
    .tdi       (tdi),
    .st        (st),
    .sel_acc   (sel_acc),
    .reg_rdata (reg_rdata),
    .reg_busy  (reg_busy),
    .reg_err   (reg_err),
    .sr_lsb    (acc_lsb),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata)
  );

  always_comb begin
    byp_n = byp;
    if (!sel_acc) begin
      if (st == ST_CAP_DR)     byp_n = 1'b0;
      else if (st == ST_SH_DR) byp_n = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_q_n) begin
    if (!rst_q_n) byp <= 1'b0;
    else          byp <= byp_n;
  end

  always_comb begin
    unique case (st)
      ST_SH_IR: tdo_n = ir_lsb;
      ST_SH_DR: tdo_n = sel_acc ? acc_lsb : byp;
      default:  tdo_n = 1'b0;
    endcase
  end

  always_ff @(negedge tck or negedge rst_q_n) begin
    if (!rst_q_n) tdo <= 1'b0;
    else          tdo <= tdo_n;
  end

endmodule

// File: rtl/jdp_chk.sv
module jdp_chk
  import jdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tms,
  input  logic              tdo,
  input  tap_st_t           st,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)               hi_cnt <= 3'd0;
    else if (!tms)            hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd5)  hi_cnt <= hi_cnt + 3'd1;
  end

  // R1
  tms_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_cnt == 3'd5) |-> (st == ST_TLR));

  // R3
  tdo_idle_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (st != ST_SH_DR && st != ST_SH_IR) |-> !tdo);

  // R10
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  // R10
  rd_pulse_chk: assert property (@(posedge tck) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R10
  wr_pulse_chk: assert property (@(posedge tck) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R5
  rd_origin_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(reg_rd) |-> ($past(st) == ST_UPD_DR));

  // R7
  wr_origin_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(reg_wr) |-> ($past(st) == ST_UPD_DR));

  // R8
  addr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(reg_addr) |-> ($past(st) == ST_UPD_DR));

endmodule

bind jdp_top jdp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .tck      (tck),
  .rst_n    (rst_q_n),
  .tms      (tms),
  .tdo      (tdo),
  .st       (st),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr)
);

// File: tb/jdp_top_tb.sv
`timescale 1ns/1ps
module jdp_top_tb;

  logic        tck = 1'b0;
  logic        rst_n, tms, tdi, tdo;
  logic [6:0]  reg_addr;
  logic        reg_rd, reg_wr, reg_busy, reg_err;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] bank [128];
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 tck = ~tck;

  jdp_top u_dut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_busy(reg_busy), .reg_err(reg_err)
  );

  // register bank model on the internal bus
  always @(posedge tck) begin
    if (reg_wr) bank[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= bank[reg_addr];
  end

  // {read, index[6:0], data[31:0]}
  localparam logic [39:0] VEC [8] = '{
    {1'b0, 7'h05, 32'hDEADBEEF},
    {1'b0, 7'h7F, 32'h12345678},
    {1'b0, 7'h00, 32'hA5A5A5A5},
    {1'b1, 7'h05, 32'hDEADBEEF},
    {1'b1, 7'h7F, 32'h12345678},
    {1'b0, 7'h05, 32'h00000000},
    {1'b1, 7'h05, 32'h00000000},
    {1'b1, 7'h00, 32'hA5A5A5A5}
  };

  task automatic chk(input logic ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic q);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    q   = tdo;
    @(posedge tck);
  endtask

  task automatic idle();
    logic q;
    step(1'b0, 1'b0, q);
  endtask

  task automatic shift_ir(input logic [4:0] code, output logic [4:0] cap);
    logic q;
    step(1'b1, 1'b0, q);
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, code[i], q);
      cap[i] = q;
    end
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
  endtask

  task automatic scan_dr(input logic [33:0] din, input int n, output logic [33:0] dout);
    logic q;
    dout = '0;
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    step(1'b0, 1'b0, q);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], q);
      dout[i] = q;
    end
    step(1'b1, 1'b0, q);
    step(1'b0, 1'b0, q);
    idle();
  endtask

  function automatic logic [33:0] addr_word(input logic rd, input logic [6:0] a);
    return {a, rd, 26'b0};
  endfunction

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    logic [33:0] o;
    scan_dr(addr_word(1'b0, a), 34, o);
    scan_dr({2'b11, d}, 34, o);
  endtask

  task automatic do_read(input logic [6:0] a, output logic [33:0] o);
    logic [33:0] oa;
    scan_dr(addr_word(1'b1, a), 34, oa);
    scan_dr(34'h0, 34, o);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [33:0] o;
    logic [4:0]  c;
    logic        q;
    rst_n = 1'b0; tms = 1'b1; tdi = 1'b0; reg_busy = 1'b0; reg_err = 1'b0;
    reg_rdata = '0;
    repeat (3) @(posedge tck);
    #1;
    // R1 reset state
    chk(tdo == 0 && reg_rd == 0 && reg_wr == 0 && reg_addr == 0, "R1 reset outputs",
        {tdo, reg_rd, reg_wr, reg_addr}, 34'h0);
    @(negedge tck);
    rst_n = 1'b1;
    repeat (4) @(posedge tck);
    idle();

    // R2 bypass selected after reset: one-bit delay, captures 0
    scan_dr(34'b1011, 4, o);
    chk(o[3:0] == 4'b0110, "R2 bypass after reset", o, 34'b0110);

    // R2 R3 IR capture pattern comes out LSB first
    shift_ir(5'b10000, c);
    chk(c == 5'b00001, "R2 R3 IR capture", {29'b0, c}, 34'b00001);

    // table walk: R4 R5 R6 R7
    foreach (VEC[k]) begin
      if (VEC[k][39]) begin
        do_read(VEC[k][38:32], o);
        chk(o == {2'b00, VEC[k][31:0]}, "R6 R5 table read", o, {2'b00, VEC[k][31:0]});
      end else begin
        scan_dr(addr_word(1'b0, VEC[k][38:32]), 34, o);
        chk(o[1:0] == 2'b00, "R4 address capture flags", o, 34'h0);
        scan_dr({2'b11, VEC[k][31:0]}, 34, o);
        chk(o[1:0] == 2'b00, "R7 write capture flags", o, 34'h0);
      end
    end

    // R8 busy during address scan: discarded, phase kept
    reg_busy = 1'b1;
    scan_dr(addr_word(1'b0, 7'h20), 34, o);
    chk(o[1:0] == 2'b01, "R8 R4 busy at bit 0", o, 34'b01);
    reg_busy = 1'b0;
    do_write(7'h20, 32'h00000055);
    do_read(7'h20, o);
    chk(o[31:0] == 32'h55, "R8 address rescan", o, 34'h55);

    // R8 R6 busy in read data phase: bit 32, rescan returns data
    scan_dr(addr_word(1'b1, 7'h7F), 34, o);
    reg_busy = 1'b1;
    scan_dr(34'h0, 34, o);
    chk(o[33:32] == 2'b01, "R8 R6 busy at bit 32", o, {2'b01, 32'h0});
    reg_busy = 1'b0;
    scan_dr(34'h0, 34, o);
    chk(o == {2'b00, 32'h12345678}, "R8 read rescan", o, {2'b00, 32'h12345678});
    do_write(7'h11, 32'hCAFEF00D);
    do_read(7'h11, o);
    chk(o[31:0] == 32'hCAFEF00D, "R8 phase back to address", o, 34'hCAFEF00D);

    // R4 R6 error flag positions
    reg_err = 1'b1;
    scan_dr(addr_word(1'b1, 7'h00), 34, o);
    chk(o[1:0] == 2'b10, "R4 error at bit 1", o, 34'b10);
    scan_dr(34'h0, 34, o);
    chk(o == {2'b10, 32'hA5A5A5A5}, "R6 error at bit 33", o, {2'b10, 32'hA5A5A5A5});
    reg_err = 1'b0;

    // R6 early exit from read scan
    scan_dr(addr_word(1'b1, 7'h20), 34, o);
    scan_dr(34'h0, 32, o);
    chk(o[31:0] == 32'h55, "R6 short read", o, 34'h55);
    do_write(7'h21, 32'h0BADCAFE);
    do_read(7'h21, o);
    chk(o[31:0] == 32'h0BADCAFE, "R6 phase after short read", o, 34'h0BADCAFE);

    // R9 reloading the instruction returns to address phase
    scan_dr(addr_word(1'b0, 7'h30), 34, o);
    shift_ir(5'b10000, c);
    do_write(7'h31, 32'h00000777);
    do_read(7'h31, o);
    chk(o[31:0] == 32'h777, "R9 reselect resets phase", o, 34'h777);

    // R1 R9 five TMS high mid-access, then bypass again
    scan_dr(addr_word(1'b0, 7'h32), 34, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, q);
    idle();
    scan_dr(34'b1101, 4, o);
    chk(o[3:0] == 4'b1010, "R1 TMS reset to bypass", o, 34'b1010);
    shift_ir(5'b10000, c);
    do_write(7'h33, 32'h13572468);
    do_read(7'h33, o);
    chk(o[31:0] == 32'h13572468, "R9 reset restores address phase", o, 34'h13572468);

    // R2 unknown code selects bypass
    shift_ir(5'b00110, c);
    scan_dr(34'b0011, 4, o);
    chk(o[3:0] == 4'b0110, "R2 unknown code bypass", o, 34'b0110);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule